// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing controller of a byte-wide serial memory that answers on a two-wire bus. A fast system clock oversamples the clock line (SCL) and data line (SDA). The engine finds start and stop conditions, shifts in bytes, and checks the slave address against a fixed type code and one external select pin. It acknowledges the bytes it accepts and runs single-byte writes, page writes, current-address reads, random reads and sequential reads. The data line is only ever pulled low. The memory is an internal register file with a 16-byte page buffer and a self-timed write cycle.

A write is collected in the page buffer and written to the array when the master sends a stop. For a programmable number of system clocks after that, the engine acknowledges no address at all. A master can therefore poll with address bytes until the engine answers, which shows the write cycle is over.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Before the first start, bytes clocked on the bus get no acknowledge, and the drive output stays released while idle.
- R2: The address byte is sent MSB first as type bits 1010, then a select bit that must equal `sel_pin`, then two high memory address bits, then R/W (1 = read). On a match the engine pulls SDA low during the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start or stop.
- R3: In write mode the next byte sets the low 8 bits of the word address. The two address-byte bits supply bits 9:8. That byte and every data byte after it are acknowledged.
- R4: During a page write, bits 3:0 of the address counter advance after each data byte and wrap within the 16-byte page, while bits 9:4 stay fixed. A later byte overwrites an earlier one at the same address. The data reaches the array at the stop.
- R5: After a stop that ends a write with at least one data byte, no address is acknowledged for `WR_CYCLES` clocks. After that, addresses are acknowledged again.
- R6: Read data goes out MSB first. The read counter advances through all 10 address bits and wraps from 0x3FF to 0x000.
- R7: After each read byte the engine samples the ninth clock. A low level makes it send the next byte. A high level makes it release SDA and send nothing more until a start or stop.
- R8: A random read (write-mode address, word address, repeated start, read-mode address) returns data from the given word address, with no stop needed in between.
- R9: A current-address read returns the byte after the last one accessed by a read or write.
- R10: A stop inside a byte abandons it, so no partial byte is written. A start inside a byte begins a new address reception.
- R11: The SDA drive is a single pull-low enable and is released after reset. It is asserted only after a detected SCL falling edge. It is released only on an SCL falling edge, a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND with all drivers) |
| sel_pin | input | 1 | Select level the address byte must carry |
| sda_drive_low | output | 1 | When high, the data line is pulled low |

## Verification
The hardest state to reach is the window right after a write stop. Only a second address byte sent during the busy period can show that acknowledges are withheld. The bench polls with write-mode address bytes straight after each stop and requires the first poll to go unanswered and a later one to be answered. Mid-byte aborts are just as hard to reach, so the bench drives raw SCL/SDA bit sequences that break off after a few bits with a stop or a repeated start. It then reads the addressed byte back to show nothing was written.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int          MEM_AW   = 10;
    localparam int          PAGE_AW  = 4;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for a start
        ST_DEV,    // receiving address byte
        ST_ACKD,   // acknowledging address byte
        ST_WADR,   // receiving word address
        ST_ACKA,   // acknowledging word address
        ST_WDAT,   // receiving write data
        ST_ACKW,   // acknowledging write data
        ST_RDAT,   // shifting read data out
        ST_RACK,   // sampling master acknowledge
        ST_RNXT,   // waiting to launch next read byte
        ST_HOLD    // ignoring bus until start/stop
    } twi_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic sel);
        return (b[7:4] == DEV_TYPE) && (b[3] == sel);
    endfunction

endpackage

// File: rtl/twi_bus_sampler.sv
module twi_bus_sampler
    import twi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [1:0] scl_sy, sda_sy;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_in};
            sda_sy <= {sda_sy[0], sda_in};
            scl_q  <= scl_sy[1];
            sda_q  <= sda_sy[1];
        end
    end

    always_comb begin
        ev.scl_rise = scl_sy[1] & ~scl_q;
        ev.scl_fall = ~scl_sy[1] & scl_q;
        ev.start    = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
        ev.stop     = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
        ev.sda      = sda_sy[1];
    end

endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
    parameter int AW        = 10,
    parameter int PW        = 4,
    parameter int WR_CYCLES = 600
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          buf_wr,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_data,
    input  logic          commit,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);

    localparam int DEPTH  = 1 << AW;
    localparam int PDEPTH = 1 << PW;
    localparam int CW     = $clog2(WR_CYCLES + 1);

    logic [7:0]       mem  [DEPTH];
    logic [7:0]       pbuf [PDEPTH];
    logic [PDEPTH-1:0] pmask;
    logic [AW-PW-1:0] pbase;
    logic [CW-1:0]    wcnt;
    logic             fire;

    assign fire    = commit && (|pmask);
    assign busy    = (wcnt != '0);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            for (int k = 0; k < PDEPTH; k++) pbuf[k] <= 8'h00;
            pmask <= '0;
            pbase <= '0;
            wcnt  <= '0;
        end else begin
            if (buf_wr) begin
                pbuf[buf_addr[PW-1:0]]  <= buf_data;
                pmask[buf_addr[PW-1:0]] <= 1'b1;
                pbase                   <= buf_addr[AW-1:PW];
            end
            if (fire) begin
                for (int j = 0; j < PDEPTH; j++)
                    if (pmask[j]) mem[{pbase, j[PW-1:0]}] <= pbuf[j];
                pmask <= '0;
                wcnt  <= CW'(WR_CYCLES);
            end else if (busy) begin
                wcnt <= wcnt - CW'(1);
            end
        end
    end

    AST_COMMIT_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        fire |-> !busy); // R5

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_pkg::*;
#(
    parameter int ADDR_W    = MEM_AW,
    parameter int PAGE_W    = PAGE_AW,
    parameter int WR_CYCLES = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sel_pin,
    output logic sda_drive_low
);

    localparam int HI_W = ADDR_W - 8;

    bus_ev_t           ev;
    twi_state_e        state;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [HI_W-1:0]   hi_q;
    logic              rw_q;
    logic [ADDR_W-1:0] ptr;
    logic              oe;
    logic              buf_wr;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_data;
    logic [7:0]        rd_data;
    logic              busy;
    logic              byte_in_done;

    twi_bus_sampler u_sampler (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    twi_page_store #(
        .AW        (ADDR_W),
        .PW        (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .buf_wr   (buf_wr),
        .buf_addr (buf_addr),
        .buf_data (buf_data),
        .commit   (ev.stop),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .busy     (busy)
    );

    assign sda_drive_low = oe;
    assign byte_in_done  = ev.scl_fall && (cnt == 4'd8);

    always_ff @(posedge clk) begin
        buf_wr <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            hi_q     <= '0;
            rw_q     <= 1'b0;
            ptr      <= '0;
            oe       <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
        end else if (ev.start) begin
            state <= ST_DEV;
            cnt   <= '0;
            oe    <= 1'b0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (ev.scl_rise && cnt < 4'd8) begin
                        shreg <= {shreg[6:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_in_done) begin
                        cnt <= '0;
                        if (state == ST_DEV) begin
                            if (dev_match(shreg, sel_pin) && !busy) begin
                                oe    <= 1'b1;
                                hi_q  <= shreg[HI_W:1];
                                rw_q  <= shreg[0];
                                state <= ST_ACKD;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end else if (state == ST_WADR) begin
                            oe    <= 1'b1;
                            ptr   <= {hi_q, shreg};
                            state <= ST_ACKA;
                        end else begin
                            oe       <= 1'b1;
                            buf_wr   <= 1'b1;
                            buf_addr <= ptr;
                            buf_data <= shreg;
                            ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                            state    <= ST_ACKW;
                        end
                    end
                end
                ST_ACKD, ST_RNXT: begin
                    if (ev.scl_fall) begin
                        if (state == ST_RNXT || rw_q) begin
                            shreg <= rd_data;
                            oe    <= ~rd_data[7];
                            ptr   <= ptr + ADDR_W'(1);
                            state <= ST_RDAT;
                        end else begin
                            oe    <= 1'b0;
                            state <= ST_WADR;
                        end
                    end
                end
                ST_ACKA, ST_ACKW: begin
                    if (ev.scl_fall) begin
                        oe    <= 1'b0;
                        state <= ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            oe    <= 1'b0;
                            cnt   <= '0;
                            state <= ST_RACK;
                        end else begin
                            oe    <= ~shreg[6];
                            shreg <= {shreg[6:0], 1'b0};
                            cnt   <= cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) state <= ev.sda ? ST_HOLD : ST_RNXT;
                end
                default: ;
            endcase
        end
    end

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> $past(ev.scl_fall)); // R11

    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_drive_low) |-> $past(ev.scl_fall || ev.start || ev.stop)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_drive_low); // R1

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_drive_low) && state == ST_ACKD) |-> !$past(busy)); // R5

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDAT && byte_in_done) |=>
            ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R4

endmodule

// File: tb/twi_eeprom_slave_tb_top.sv
module twi_eeprom_slave_tb_top;

    localparam int Q   = 10;
    localparam int WRC = 600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sel = 1'b1;
    logic oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] ref_mem [1024];
    logic [9:0] ref_ptr = '0;
    logic [7:0] wbuf [32];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~oe;

    twi_eeprom_slave #(.WR_CYCLES(WRC)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl),
        .sda_in        (sda_line),
        .sel_pin       (sel),
        .sda_drive_low (oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic [1:0] hi, input logic rw);
        return {4'b1010, sel, hi, rw};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b0; wt(Q);
        scl = 1'b0;   wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wt(Q);
            scl = 1'b1;     wt(Q);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q/2);
        ack = ~sda_line; wt(Q/2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wt(Q);
            scl = 1'b1; wt(Q/2);
            d = {d[6:0], sda_line}; wt(Q/2);
            scl = 1'b0;
        end
        sda_m = ~mack; wt(Q);
        scl = 1'b1;    wt(Q);
        scl = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [9:0] a);
        bit ack;
        bus_start();
        send_byte(dev(a[9:8], 1'b0), ack); chk("R2 address ack", ack, 1);
        send_byte(a[7:0], ack);            chk("R3 word address ack", ack, 1);
        ref_ptr = a;
    endtask

    task automatic do_write(input logic [9:0] a, input int n);
        bit ack;
        set_addr(a);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); chk("R3 data ack", ack, 1);
            ref_mem[ref_ptr] = wbuf[i];
            ref_ptr = {ref_ptr[9:4], ref_ptr[3:0] + 4'd1};
        end
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        bit ack;
        polls = 0;
        do begin
            bus_start();
            send_byte(dev(2'b00, 1'b0), ack);
            bus_stop();
            polls++;
        end while (!ack && polls < 50);
        chk("R5 ready after write cycle", ack, 1);
    endtask

    task automatic do_read(input bit random, input logic [9:0] a, input int n,
                           input string req, input bit keep_open);
        bit ack;
        logic [7:0] d;
        if (random) set_addr(a);
        bus_start();
        send_byte(dev(2'b00, 1'b1), ack); chk("R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(req, d, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 10'd1;
        end
        if (!keep_open) bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        int polls;
        logic [7:0] d;
        logic [9:0] a;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) ref_mem[i] = 8'hFF;
        wt(5);
        rst = 1'b0;
        wt(5);
        chk("R11 drive released after reset", oe, 0);

        // R1: no response before a start
        send_byte(dev(2'b00, 1'b0), ack);
        chk("R1 no ack before start", ack, 0);

        // R2: select mismatch and type mismatch
        bus_start();
        send_byte(8'hA0, ack); chk("R2 select mismatch nack", ack, 0);
        send_byte(8'h00, ack); chk("R2 ignored after mismatch", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hB8, ack); chk("R2 type mismatch nack", ack, 0);
        bus_stop();

        // R3/R5: write two bytes, busy window, polling
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC7;
        do_write(10'h2F5, 2);
        wait_ready(polls);
        chk("R5 first poll unanswered", int'(polls > 1), 1);

        // R8 random read then R9 current-address read
        do_read(1'b1, 10'h2F5, 1, "R8 random read data", 1'b0);
        do_read(1'b0, 10'h000, 1, "R9 current address data", 1'b0);

        // R4: page write rolling over
        for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h10 + i);
        do_write(10'h13C, 20);
        wait_ready(polls);
        do_read(1'b1, 10'h130, 16, "R4 page wrap data", 1'b0);

        // R6: sequential read across top of array
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        do_write(10'h3FE, 2);
        wait_ready(polls);
        wbuf[0] = 8'h71; wbuf[1] = 8'h72;
        do_write(10'h000, 2);
        wait_ready(polls);
        do_read(1'b1, 10'h3FE, 3, "R6 wrap read data", 1'b0);
        do_read(1'b0, 10'h000, 1, "R9 current after wrap", 1'b0);

        // R7: master nack ends transmission
        do_read(1'b1, 10'h13D, 1, "R7 byte before nack", 1'b1);
        recv_byte(1'b0, d);
        chk("R7 bus released after nack", d, 8'hFF);
        bus_stop();

        // R10: stop mid-byte leaves memory unchanged
        wbuf[0] = 8'h3C;
        do_write(10'h055, 1);
        wait_ready(polls);
        set_addr(10'h055);
        send_bits(8'hC3, 4);
        bus_stop();
        do_read(1'b1, 10'h055, 1, "R10 stop aborted write", 1'b0);
        // R10: start mid-byte restarts address reception
        bus_start();
        send_bits(8'hA5, 3);
        bus_start();
        send_byte(dev(2'b00, 1'b1), ack);
        chk("R10 restart ack", ack, 1);
        recv_byte(1'b0, d);
        chk("R10 read after restart", d, ref_mem[ref_ptr]);
        ref_ptr = ref_ptr + 10'd1;
        bus_stop();

        // Random page writes, checked by reading the whole page
        for (int it = 0; it < 6; it++) begin
            a = 10'($urandom % 1024);
            n = 1 + int'($urandom % 20);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(a, n);
            wait_ready(polls);
            chk("R5 random poll unanswered first", int'(polls > 1), 1);
            do_read(1'b1, {a[9:4], 4'h0}, 16, "R4 random page data", 1'b0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule